// File: doc/BRIEF.md
# USB-PD Sink Contract Selector

This block holds the decision logic of a USB Power Delivery sink port. After reset it decodes four strap voltages, already digitised to millivolts, into a voltage window and a current need. It then waits for the attached source to advertise its offers. The source's offers arrive as a flat list. Each entry carries a voltage and a maximum current. The block picks the entry that fits the window and the current need, and hands the protocol layer a request made of an index and a current.

When the protocol layer reports that the contract is accepted, the block turns on one of two gate enables. The main path enable is used when an offer fitted. The safe-rail enable is used when the block fell back to the 5 V entry.

While the main path is on, the block watches the measured bus voltage against a window that is widened by 20 %. When the voltage leaves that window, the block opens the path, raises the fault flag and asks for a protocol reset. It also reports the plug orientation from the CC attach status. A detach drops everything back to idle.

Top module: `pd_sink_selector`

## Requirements
- R1: Each voltage strap decodes by band: below 249 mV gives 5 V, 249–786 gives 9 V, 787–1347 gives 12 V, 1348–1920 gives 15 V, 1921–2778 gives 19 V, and 2779 mV or more gives 20 V.
- R2: The coarse current strap uses the same six bands and decodes to 0, 1, 2, 3, 4 and 5 A, lowest band first.
- R3: The fine current strap adds a value by band: +0 mA below 249 mV, +250 mA for 249–786, +500 mA for 787–1347, +750 mA for 1348–1920, and +900 mA at 1921 mV or more. The needed current is coarse plus fine, and it is reported on `req_ma_o` when an offer fits.
- R4: The straps are sampled once, on the first clock after reset, and are held until the next reset. If the decoded minimum exceeds the decoded maximum, the maximum is used as both limits.
- R5: Only the first `offer_cnt_i` entries count, with index 0 first. An entry fits when its voltage lies within [min, max] and its current is at least the needed current. Among the fitting entries, the highest voltage wins, and a tie goes to the lowest index, which is reported on `req_idx_o`.
- R6: When nothing fits, the request is index 0 (the 5 V entry) with `req_ma_o` = min(need, entry 0 current), and `fault_o` rises with the request. After acceptance, `safe_en_o` is high and `main_en_o` is low, and the voltage window is not enforced.
- R7: When an entry fits, acceptance drives `main_en_o` high and `safe_en_o` low, and `fault_o` stays low.
- R8: While the main path is on, the block trips if 5·vbus < 4·min or 5·vbus > 6·max. On a trip, the next cycle shows `main_en_o` low, `fault_o` high and a one-cycle `proto_reset_o` pulse, and the block waits for new offers. The fault clears at the next acceptance.
- R9: `cc_state_i` uses 00 for none, 01 for CC1, 10 for CC2 and 11 for invalid (treated as none). `flip_o` is high only for 10.
- R10: When not attached, both enables and `fault_o` drop within one cycle, the block returns to idle, and `src_caps_i` is ignored, so no request is issued.
- R11: `req_valid_o` is a one-cycle pulse in the cycle after the cycle in which `src_caps_i` is sampled. Acceptance (`neg_done_i`) counts only after that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vmin_strap_i | input | 12 | Minimum-voltage strap level, mV |
| vmax_strap_i | input | 12 | Maximum-voltage strap level, mV |
| icoarse_strap_i | input | 12 | Coarse current strap level, mV |
| ifine_strap_i | input | 12 | Fine current strap level, mV |
| cc_state_i | input | 2 | Attach / orientation status |
| src_caps_i | input | 1 | Offer list valid pulse |
| offer_cnt_i | input | CNT_W (3) | Number of valid offers |
| offer_mv_i | input | NUM_OFFERS*16 | Offer voltages in mV, entry i at bits [16i+15:16i] |
| offer_ma_i | input | NUM_OFFERS*16 | Offer maximum currents in mA, same layout |
| neg_done_i | input | 1 | Contract accepted pulse |
| vbus_mv_i | input | 16 | Measured bus voltage, mV |
| req_valid_o | output | 1 | Request pulse |
| req_idx_o | output | IDX_W (3) | Requested offer index |
| req_ma_o | output | 16 | Requested current, mA |
| main_en_o | output | 1 | Main path gate enable |
| safe_en_o | output | 1 | Safe 5 V rail gate enable |
| fault_o | output | 1 | Fault flag |
| flip_o | output | 1 | Orientation flag |
| proto_reset_o | output | 1 | Protocol reset request pulse |

## Verification
Offer lists are built so that each one separates a single rule from the others.

- **Highest voltage wins:** one list has several fitting entries at different voltages, which shows that the block picks by voltage and not by list order.
- **Tie-break:** another list holds equal-voltage fitting entries, which shows the lowest-index rule.
- **Offer count:** a list shortened by the count forces the fallback, which shows that entries past the count are ignored.
- **Swap rule and hold:** a strap set with the minimum above the maximum, changed after reset, must still exclude higher-voltage offers.
- **Band edges:** strap values one millivolt on either side of a band edge, paired with offers that miss the current need by one milliamp, pin down the decode edges.
- **Trip window:** the measured voltage is set exactly on each limit and then one millivolt past it, to place the trip threshold.

// File: rtl/pd_sink_pkg.sv
package pd_sink_pkg;
  localparam int unsigned STRAP_W = 12;
  localparam int unsigned MV_W    = 16;
  localparam int unsigned MA_W    = 16;

  typedef enum logic [1:0] {
    CC_NONE = 2'b00,
    CC_ONE  = 2'b01,
    CC_TWO  = 2'b10,
    CC_BAD  = 2'b11
  } cc_state_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_CAPS,
    ST_REQ,
    ST_WAIT_ACK,
    ST_CONTRACT
  } sink_state_e;

  typedef struct packed {
    logic [MV_W-1:0] vmin_mv;
    logic [MV_W-1:0] vmax_mv;
    logic [MA_W-1:0] need_ma;
  } sink_limits_t;

  function automatic logic [2:0] strap_band(input logic [STRAP_W-1:0] mv);
    logic [2:0] b;
    b = 3'd0;
    if (mv >= STRAP_W'(249))  b = 3'd1;
    if (mv >= STRAP_W'(787))  b = 3'd2;
    if (mv >= STRAP_W'(1348)) b = 3'd3;
    if (mv >= STRAP_W'(1921)) b = 3'd4;
    if (mv >= STRAP_W'(2779)) b = 3'd5;
    return b;
  endfunction

  function automatic logic [MV_W-1:0] band_volt_mv(input logic [2:0] b);
    case (b)
      3'd0:    return MV_W'(5000);
      3'd1:    return MV_W'(9000);
      3'd2:    return MV_W'(12000);
      3'd3:    return MV_W'(15000);
      3'd4:    return MV_W'(19000);
      default: return MV_W'(20000);
    endcase
  endfunction

  function automatic logic [MA_W-1:0] band_coarse_ma(input logic [2:0] b);
    case (b)
      3'd0:    return MA_W'(0);
      3'd1:    return MA_W'(1000);
      3'd2:    return MA_W'(2000);
      3'd3:    return MA_W'(3000);
      3'd4:    return MA_W'(4000);
      default: return MA_W'(5000);
    endcase
  endfunction

  // fine strap saturates at its fifth band
  function automatic logic [MA_W-1:0] band_fine_ma(input logic [2:0] b);
    case (b)
      3'd0:    return MA_W'(0);
      3'd1:    return MA_W'(250);
      3'd2:    return MA_W'(500);
      3'd3:    return MA_W'(750);
      default: return MA_W'(900);
    endcase
  endfunction
endpackage

// File: rtl/pd_strap_capture.sv
module pd_strap_capture
  import pd_sink_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [STRAP_W-1:0] vmin_strap_i,
  input  logic [STRAP_W-1:0] vmax_strap_i,
  input  logic [STRAP_W-1:0] icoarse_strap_i,
  input  logic [STRAP_W-1:0] ifine_strap_i,
  output sink_limits_t       lim_o,
  output logic               valid_o
);
  sink_limits_t lim_d, lim_q;
  logic         valid_q;

  always_comb begin
    lim_d.vmin_mv = band_volt_mv(strap_band(vmin_strap_i));
    lim_d.vmax_mv = band_volt_mv(strap_band(vmax_strap_i));
    if (lim_d.vmin_mv > lim_d.vmax_mv) lim_d.vmin_mv = lim_d.vmax_mv;
    lim_d.need_ma = band_coarse_ma(strap_band(icoarse_strap_i))
                  + band_fine_ma(strap_band(ifine_strap_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q   <= '0;
      valid_q <= 1'b0;
    end else if (!valid_q) begin
      lim_q   <= lim_d;
      valid_q <= 1'b1;
    end
  end

  assign lim_o   = lim_q;
  assign valid_o = valid_q;

  AST_STRAP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(valid_o) |-> $stable(lim_o)); // R4
  AST_MIN_NOT_ABOVE_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> lim_o.vmin_mv <= lim_o.vmax_mv); // R4
endmodule

// File: rtl/pd_offer_scan.sv
module pd_offer_scan
  import pd_sink_pkg::*;
#(
  parameter  int unsigned NUM_OFFERS = 7,
  localparam int unsigned IDX_W = (NUM_OFFERS > 1) ? $clog2(NUM_OFFERS) : 1,
  localparam int unsigned CNT_W = $clog2(NUM_OFFERS + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  sink_limits_t               lim_i,
  input  logic [CNT_W-1:0]           offer_cnt_i,
  input  logic [NUM_OFFERS*MV_W-1:0] offer_mv_i,
  input  logic [NUM_OFFERS*MA_W-1:0] offer_ma_i,
  output logic                       fit_o,
  output logic [IDX_W-1:0]           idx_o,
  output logic [MA_W-1:0]            req_ma_o
);
  logic [MV_W-1:0]       ent_mv [NUM_OFFERS];
  logic [MA_W-1:0]       ent_ma [NUM_OFFERS];
  logic [NUM_OFFERS-1:0] ok;

  for (genvar g = 0; g < NUM_OFFERS; g++) begin : g_ent
    assign ent_mv[g] = offer_mv_i[g*MV_W +: MV_W];
    assign ent_ma[g] = offer_ma_i[g*MA_W +: MA_W];
    assign ok[g] = (CNT_W'(g) < offer_cnt_i)
                && (ent_mv[g] >= lim_i.vmin_mv) && (ent_mv[g] <= lim_i.vmax_mv)
                && (ent_ma[g] >= lim_i.need_ma);
  end

  logic            found;
  logic [IDX_W-1:0] best_idx;
  logic [MV_W-1:0]  best_mv;

  // strict > keeps the lowest index on equal voltage
  always_comb begin
    found    = 1'b0;
    best_idx = '0;
    best_mv  = '0;
    for (int i = 0; i < NUM_OFFERS; i++) begin
      if (ok[i] && (!found || ent_mv[i] > best_mv)) begin
        found    = 1'b1;
        best_idx = IDX_W'(i);
        best_mv  = ent_mv[i];
      end
    end
  end

  assign fit_o    = found;
  assign idx_o    = best_idx;
  assign req_ma_o = found ? lim_i.need_ma
                  : ((ent_ma[0] < lim_i.need_ma) ? ent_ma[0] : lim_i.need_ma);

  logic [MV_W-1:0] sel_mv;
  logic [MA_W-1:0] sel_ma;
  assign sel_mv = offer_mv_i[int'(idx_o)*MV_W +: MV_W];
  assign sel_ma = offer_ma_i[int'(idx_o)*MA_W +: MA_W];

  AST_PICK_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fit_o |-> (sel_mv >= lim_i.vmin_mv) && (sel_mv <= lim_i.vmax_mv)); // R5
  AST_PICK_HAS_CURRENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fit_o |-> sel_ma >= lim_i.need_ma); // R5
  AST_FALLBACK_IDX_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fit_o |-> idx_o == '0); // R6
endmodule

// File: rtl/pd_vbus_window.sv
module pd_vbus_window
  import pd_sink_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [MV_W-1:0] vmin_mv_i,
  input  logic [MV_W-1:0] vmax_mv_i,
  input  logic [MV_W-1:0] vbus_mv_i,
  output logic            low_o,
  output logic            high_o
);
  localparam int unsigned PW = MV_W + 3;

  logic [PW-1:0] vbus_x5, min_x4, max_x6;

  assign vbus_x5 = (PW'(vbus_mv_i) << 2) + PW'(vbus_mv_i);
  assign min_x4  = PW'(vmin_mv_i) << 2;
  assign max_x6  = (PW'(vmax_mv_i) << 2) + (PW'(vmax_mv_i) << 1);

  assign low_o  = vbus_x5 < min_x4;
  assign high_o = vbus_x5 > max_x6;

  AST_WINDOW_ONE_SIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(low_o && high_o)); // R8
endmodule

// File: rtl/pd_sink_selector.sv
module pd_sink_selector
  import pd_sink_pkg::*;
#(
  parameter  int unsigned NUM_OFFERS = 7,
  localparam int unsigned IDX_W = (NUM_OFFERS > 1) ? $clog2(NUM_OFFERS) : 1,
  localparam int unsigned CNT_W = $clog2(NUM_OFFERS + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [STRAP_W-1:0]         vmin_strap_i,
  input  logic [STRAP_W-1:0]         vmax_strap_i,
  input  logic [STRAP_W-1:0]         icoarse_strap_i,
  input  logic [STRAP_W-1:0]         ifine_strap_i,
  input  logic [1:0]                 cc_state_i,
  input  logic                       src_caps_i,
  input  logic [CNT_W-1:0]           offer_cnt_i,
  input  logic [NUM_OFFERS*MV_W-1:0] offer_mv_i,
  input  logic [NUM_OFFERS*MA_W-1:0] offer_ma_i,
  input  logic                       neg_done_i,
  input  logic [MV_W-1:0]            vbus_mv_i,
  output logic                       req_valid_o,
  output logic [IDX_W-1:0]           req_idx_o,
  output logic [MA_W-1:0]            req_ma_o,
  output logic                       main_en_o,
  output logic                       safe_en_o,
  output logic                       fault_o,
  output logic                       flip_o,
  output logic                       proto_reset_o
);
  sink_limits_t     lim;
  logic             lim_valid;
  logic             scan_fit;
  logic [IDX_W-1:0] scan_idx;
  logic [MA_W-1:0]  scan_ma;
  logic             win_low, win_high;

  pd_strap_capture u_straps (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .vmin_strap_i   (vmin_strap_i),
    .vmax_strap_i   (vmax_strap_i),
    .icoarse_strap_i(icoarse_strap_i),
    .ifine_strap_i  (ifine_strap_i),
    .lim_o          (lim),
    .valid_o        (lim_valid)
  );

  pd_offer_scan #(.NUM_OFFERS(NUM_OFFERS)) u_scan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lim_i      (lim),
    .offer_cnt_i(offer_cnt_i),
    .offer_mv_i (offer_mv_i),
    .offer_ma_i (offer_ma_i),
    .fit_o      (scan_fit),
    .idx_o      (scan_idx),
    .req_ma_o   (scan_ma)
  );

  pd_vbus_window u_window (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vmin_mv_i(lim.vmin_mv),
    .vmax_mv_i(lim.vmax_mv),
    .vbus_mv_i(vbus_mv_i),
    .low_o    (win_low),
    .high_o   (win_high)
  );

  cc_state_e cc;
  logic      attached;
  assign cc       = cc_state_e'(cc_state_i);
  assign attached = (cc == CC_ONE) || (cc == CC_TWO);

  sink_state_e      state_q;
  logic             fit_q, nofit_q, vfault_q, main_q, safe_q, preset_q;
  logic [IDX_W-1:0] idx_q;
  logic [MA_W-1:0]  ma_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      fit_q    <= 1'b0;
      nofit_q  <= 1'b0;
      vfault_q <= 1'b0;
      main_q   <= 1'b0;
      safe_q   <= 1'b0;
      preset_q <= 1'b0;
      idx_q    <= '0;
      ma_q     <= '0;
    end else begin
      preset_q <= 1'b0;
      if (!attached) begin
        state_q  <= ST_IDLE;
        main_q   <= 1'b0;
        safe_q   <= 1'b0;
        nofit_q  <= 1'b0;
        vfault_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: if (lim_valid) state_q <= ST_WAIT_CAPS;
          ST_WAIT_CAPS, ST_CONTRACT: begin
            if (src_caps_i) begin
              fit_q   <= scan_fit;
              idx_q   <= scan_idx;
              ma_q    <= scan_ma;
              nofit_q <= !scan_fit;
              state_q <= ST_REQ;
            end else if (state_q == ST_CONTRACT && main_q && (win_low || win_high)) begin
              main_q   <= 1'b0;
              vfault_q <= 1'b1;
              preset_q <= 1'b1;
              state_q  <= ST_WAIT_CAPS;
            end
          end
          ST_REQ: state_q <= ST_WAIT_ACK;
          ST_WAIT_ACK: if (neg_done_i) begin
            main_q   <= fit_q;
            safe_q   <= !fit_q;
            vfault_q <= 1'b0;
            state_q  <= ST_CONTRACT;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign req_valid_o   = (state_q == ST_REQ);
  assign req_idx_o     = idx_q;
  assign req_ma_o      = ma_q;
  assign main_en_o     = main_q;
  assign safe_en_o     = safe_q;
  assign fault_o       = nofit_q | vfault_q;
  assign flip_o        = (cc == CC_TWO);
  assign proto_reset_o = preset_q;

  AST_ENABLES_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(main_en_o && safe_en_o)); // R6
  AST_DETACH_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !attached |=> !main_en_o && !safe_en_o && !fault_o); // R10
  AST_TRIP_PATH_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_reset_o |-> !main_en_o && fault_o); // R8
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |=> !req_valid_o); // R11
  AST_REQ_AFTER_CAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_valid_o) |-> $past(src_caps_i)); // R11
endmodule

// File: tb/pd_sink_selector_bench.sv
module pd_sink_selector_bench;
  localparam int N = 7;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] vmin_s, vmax_s, ic_s, if_s;
  logic [1:0]  cc;
  logic        caps, ack;
  logic [2:0]  cnt;
  logic [15:0] omv [N];
  logic [15:0] oma [N];
  logic [N*16-1:0] offer_mv, offer_ma;
  logic [15:0] vbus;
  logic        req_valid, main_en, safe_en, fault, flip, preset;
  logic [2:0]  req_idx;
  logic [15:0] req_ma;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      offer_mv[i*16 +: 16] = omv[i];
      offer_ma[i*16 +: 16] = oma[i];
    end
  end

  pd_sink_selector #(.NUM_OFFERS(N)) u_pd_sink_selector (
    .clk_i(clk), .rst_ni(rst_ni),
    .vmin_strap_i(vmin_s), .vmax_strap_i(vmax_s),
    .icoarse_strap_i(ic_s), .ifine_strap_i(if_s),
    .cc_state_i(cc), .src_caps_i(caps), .offer_cnt_i(cnt),
    .offer_mv_i(offer_mv), .offer_ma_i(offer_ma),
    .neg_done_i(ack), .vbus_mv_i(vbus),
    .req_valid_o(req_valid), .req_idx_o(req_idx), .req_ma_o(req_ma),
    .main_en_o(main_en), .safe_en_o(safe_en), .fault_o(fault),
    .flip_o(flip), .proto_reset_o(preset)
  );

  typedef struct { string tag; int idx; int ma; } exp_t;
  exp_t exp_q[$];
  int n_checks = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // monitor: pops one expected request per pulse
  always @(negedge clk) begin
    if (rst_ni && req_valid) begin
      if (exp_q.size() == 0) begin
        n_checks++;
        n_fail++;
        $display("FAIL R10 unexpected request actual idx=%0d expected none", req_idx);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.tag, " index"}, int'(req_idx), e.idx);
        chk({e.tag, " current"}, int'(req_ma), e.ma);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input int a, input int b, input int c, input int d);
    rst_ni = 1'b0; cc = 2'b00;
    vmin_s = 12'(a); vmax_s = 12'(b); ic_s = 12'(c); if_s = 12'(d);
    cyc(3);
    rst_ni = 1'b1;
    cyc(2);
  endtask

  task automatic send_caps(input string tag, input int idx, input int ma);
    exp_t e;
    e.tag = tag; e.idx = idx; e.ma = ma;
    exp_q.push_back(e);
    caps = 1'b1;
    cyc(1);
    caps = 1'b0;
    cyc(1);
    chk("R11 request drained", exp_q.size(), 0);
  endtask

  task automatic accept();
    ack = 1'b1;
    cyc(1);
    ack = 1'b0;
  endtask

  task automatic set_offer(input int i, input int mv, input int ma);
    omv[i] = 16'(mv); oma[i] = 16'(ma);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R11 watchdog actual=timeout expected=done");
    finish_test();
  end

  initial begin
    caps = 0; ack = 0; cnt = 0; vbus = 0; cc = 0;
    vmin_s = 0; vmax_s = 0; ic_s = 0; if_s = 0;
    for (int i = 0; i < N; i++) begin omv[i] = 0; oma[i] = 0; end
    cyc(2);
    chk("R10 reset main", int'(main_en), 0);
    chk("R10 reset safe", int'(safe_en), 0);
    chk("R10 reset fault", int'(fault), 0);
    chk("R10 reset req", int'(req_valid), 0);

    // config A: 12..19 V, 3 A + 500 mA
    do_reset(1000, 2000, 1500, 800);
    cc = 2'b01; cyc(1);
    chk("R9 cc1 flip", int'(flip), 0);
    set_offer(0, 5000, 3000);  set_offer(1, 9000, 3000);
    set_offer(2, 12000, 5000); set_offer(3, 15000, 3000);
    set_offer(4, 20000, 5000); set_offer(5, 15000, 4000);
    set_offer(6, 19000, 3500);
    cnt = 3'd7; vbus = 16'd15000;
    send_caps("R5 highest voltage", 6, 3500);
    chk("R7 fault before accept", int'(fault), 0);
    accept();
    chk("R7 main on", int'(main_en), 1);
    chk("R7 safe off", int'(safe_en), 0);
    chk("R7 fault low", int'(fault), 0);

    vbus = 16'd9600; cyc(2);
    chk("R8 low limit exact keeps main", int'(main_en), 1);
    vbus = 16'd9599; cyc(1);
    chk("R8 low trip main", int'(main_en), 0);
    chk("R8 low trip fault", int'(fault), 1);
    chk("R8 low trip reset pulse", int'(preset), 1);
    cyc(1);
    chk("R8 reset pulse one cycle", int'(preset), 0);
    vbus = 16'd15000;
    send_caps("R8 recovery", 6, 3500);
    accept();
    chk("R8 fault cleared", int'(fault), 0);
    chk("R8 main back", int'(main_en), 1);
    vbus = 16'd22800; cyc(2);
    chk("R8 high limit exact keeps main", int'(main_en), 1);
    vbus = 16'd22801; cyc(1);
    chk("R8 high trip main", int'(main_en), 0);
    chk("R8 high trip fault", int'(fault), 1);
    vbus = 16'd15000;

    // tie on 15 V: lowest index wins
    set_offer(0, 5000, 3000);  set_offer(1, 15000, 4000);
    set_offer(2, 20000, 5000); set_offer(3, 15000, 4000);
    set_offer(4, 15000, 3000); set_offer(5, 9000, 5000);
    set_offer(6, 12000, 3000);
    send_caps("R5 tie lowest index", 1, 3500);
    accept();
    chk("R5 tie main on", int'(main_en), 1);

    // count limits list to entry 0 -> fallback
    cnt = 3'd1;
    exp_q.push_back('{"R6 fallback", 0, 3000});
    caps = 1'b1; cyc(1); caps = 1'b0;
    chk("R6 fault with request", int'(fault), 1);
    cyc(1);
    accept();
    chk("R6 safe on", int'(safe_en), 1);
    chk("R6 main off", int'(main_en), 0);
    vbus = 16'd5000; cyc(2);
    chk("R6 window ignored on safe rail", int'(safe_en), 1);
    chk("R6 no reset on safe rail", int'(preset), 0);

    // detach
    cc = 2'b00; cyc(1);
    chk("R10 detach main", int'(main_en), 0);
    chk("R10 detach safe", int'(safe_en), 0);
    chk("R10 detach fault", int'(fault), 0);
    cnt = 3'd7;
    caps = 1'b1; cyc(1); caps = 1'b0; cyc(3);
    chk("R10 caps ignored, no request", int'(req_valid), 0);
    cc = 2'b10; cyc(1);
    chk("R9 cc2 flip", int'(flip), 1);
    cc = 2'b11; cyc(1);
    chk("R9 invalid flip", int'(flip), 0);
    cc = 2'b00; cyc(1);

    // config B: min 20 V > max 9 V -> both 9 V; need 0 + 900 mA
    do_reset(3000, 300, 0, 2000);
    vmin_s = 12'd0; vmax_s = 12'd3000; ic_s = 12'd0; if_s = 12'd0;
    cc = 2'b10; cyc(1);
    set_offer(0, 5000, 3000);  set_offer(1, 9000, 900);
    set_offer(2, 9000, 2000);  set_offer(3, 12000, 3000);
    set_offer(4, 20000, 5000);
    cnt = 3'd5; vbus = 16'd9000;
    send_caps("R4 swap and hold", 1, 900);
    accept();
    chk("R4 main on", int'(main_en), 1);
    vbus = 16'd7199; cyc(1);
    chk("R8 swapped min trip", int'(fault), 1);
    vbus = 16'd9000;

    // config C: 5..9 V, 5 A + 900 mA at band edges
    do_reset(248, 249, 2779, 1921);
    cc = 2'b01; cyc(1);
    set_offer(0, 5000, 5899); set_offer(1, 9000, 5899);
    set_offer(2, 9000, 5900); set_offer(3, 5000, 6000);
    cnt = 3'd4; vbus = 16'd9000;
    send_caps("R1 R2 R3 upper band edges", 2, 5900);
    accept();
    chk("R3 main on", int'(main_en), 1);
    cnt = 3'd2;
    send_caps("R6 fallback capped current", 0, 5899);
    accept();
    chk("R6 safe after reselect", int'(safe_en), 1);
    chk("R6 main off after reselect", int'(main_en), 0);

    // config D: 12 V > 9 V swap; coarse 2778 -> 4 A, fine 1920 -> +750
    do_reset(787, 786, 2778, 1920);
    cc = 2'b01; cyc(1);
    set_offer(0, 5000, 5000); set_offer(1, 9000, 4749);
    set_offer(2, 9000, 4750); set_offer(3, 12000, 5000);
    cnt = 3'd4;
    send_caps("R1 R2 R3 lower band edges", 2, 4750);
    accept();
    chk("R2 main on", int'(main_en), 1);

    cyc(2);
    finish_test();
  end
endmodule